// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor pipeline. At each instruction boundary the pipeline asserts a check strobe. The block then decides whether a trap must be taken. A trap is taken for a nonzero exception code from the execute stage, or for an interrupt request that the current status word permits. When a trap is taken, the block latches the cause, the status word and the program counter. It then runs one of three entry paths.

If the status word shows a pending fatal condition, the block first writes a three-word crash record to memory. It issues the writes one at a time over a valid/ready port. After the record, or straight away if no record is needed, the block saves the state in one of two places. If a trap is already being handled, it uses the duplexed save pair and jumps to a fixed vector. Otherwise it uses the regular save pair and jumps to a vector derived from the cause.

The apply step lasts one cycle. In that cycle the block presents the new PC, the updated status word and the save values with their write enables, and asks the pipeline to refetch. The pipeline treats these outputs as register writes.

Top module: `exc_entry_seq`

## Requirements
- R1: An interrupt is taken only when `chk_en` is high, `exc_code` is zero, at least one `irq_req` line is high, and status bits ID (bit 12), EP (bit 14) and NP (bit 15) of `psw_in` are all clear. When no trap is taken, `busy` and `refetch` stay low.
- R2: For an accepted interrupt, the highest-numbered active line L (0 to 4) wins. The cause is 0xFE00 | (L << 4).
- R3: A nonzero `exc_code` is taken whatever the status flags and the request lines are, and that code becomes the cause.
- R4: When NP is set, three 32-bit writes go out in this order: address 0 with 0xFFFF0000 | cause, address 4 with the latched status word, and address 8 with the latched PC. Address and data stay stable while `mem_ready` is low. Each write advances only on a cycle where valid and ready are both high.
- R5: When EP is set, the apply cycle raises `save_dup_we` and not `save_reg_we`. In that cycle `save_cause`, `save_pc` and `save_psw` carry the latched values, and `new_pc` is 0xFFFFFFD0.
- R6: When EP is clear, the apply cycle raises `save_reg_we` and not `save_dup_we`, with the same save values. `new_pc` is 0xFFFF0000 | (cause & 0xFFF0). An undefined-instruction cause of 0xFF90 therefore vectors to 0xFFFFFF90.
- R7: On the regular path, a vector that would be 0xFFFFFF70 becomes 0xFFFFFF60.
- R8: When cause bits 15:8 are 0xFE, `psw_out` bits 19:16 take the value of cause bits 7:4. For any other cause, those bits keep their latched value.
- R9: In the apply cycle, `psw_out` has AE (bit 13) cleared and ID (bit 12) set. Every other bit matches the latched status word, apart from the level field under R8.
- R10: The apply cycle is a single-cycle pulse of `refetch`. It comes one cycle after the taking edge when no record is written. When a record is written, it comes one cycle after the edge that accepts the last write. `busy` is high from the taking edge until the apply cycle ends. `chk_en` and the data inputs are ignored while `busy` is high.
- R11: After reset, `busy`, `refetch`, `mem_valid`, `save_reg_we` and `save_dup_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Instruction-boundary check strobe |
| irq_req | input | 5 | Interrupt request lines, line 4 highest |
| exc_code | input | 16 | Exception code from execute, zero for none |
| psw_in | input | 32 | Current packed status word |
| pc_in | input | 32 | Current program counter |
| mem_ready | input | 1 | Memory accepts the current write |
| busy | output | 1 | Entry sequence in progress |
| mem_valid | output | 1 | Crash-record write valid |
| mem_addr | output | 32 | Crash-record write address |
| mem_data | output | 32 | Crash-record write data |
| refetch | output | 1 | Apply cycle; pipeline refetches from new_pc |
| new_pc | output | 32 | Handler address |
| psw_out | output | 32 | Updated status word |
| save_pc | output | 32 | PC to save |
| save_psw | output | 32 | Status word to save |
| save_cause | output | 16 | Cause to save |
| save_reg_we | output | 1 | Write the regular save pair and cause field |
| save_dup_we | output | 1 | Write the duplexed save pair and fatal cause field |

## Verification
Some internal faults would show up at the ports in the apply cycle, at most four cycles after the strobe plus any stall cycles. A wrong latch shows as a save value that differs from the inputs at the taking edge. A wrong arbitration shows as the wrong cause and vector. A wrong flag decode shows as the wrong write enable or vector. Other faults show during the crash record. A slip in the record counter shows as a misplaced address or data word, or as a `refetch` that comes too early or too late against the handshake. A sequencer that fails to return to idle shows up one cycle after the apply pulse, as `busy` still being high.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the trap entry sequencer.
// Assumes a 32-bit datapath and 16-bit cause codes.
package exc_entry_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 16;
    localparam int LVL_W   = 4;

    // Packed status word bit positions; other blocks decode them.
    localparam int PSW_LVL_LSB = 16;
    localparam int PSW_NP      = 15;
    localparam int PSW_EP      = 14;
    localparam int PSW_AE      = 13;
    localparam int PSW_ID      = 12;

    localparam logic [7:0]      IRQ_CLASS   = 8'hFE;
    localparam logic [15:0]     VEC_HI      = 16'hFFFF;
    localparam logic [15:0]     CAUSE_MASK  = 16'hFFF0;
    localparam logic [XLEN-1:0] VEC_DUP     = 32'hFFFFFFD0;
    localparam logic [XLEN-1:0] VEC_ALIAS   = 32'hFFFFFF70;
    localparam logic [XLEN-1:0] VEC_ALIASED = 32'hFFFFFF60;
    localparam int              DUMP_WORDS  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DUMP  = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/exc_irq_arbiter.sv
// Decides whether a trap is taken and forms its cause code.
// Assumes NUM_IRQ <= 2**LVL_W. A nonzero exception code wins over requests.
module exc_irq_arbiter
    import exc_entry_pkg::*;
#(
    parameter int NUM_IRQ = 5
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [CAUSE_W-1:0] exc_code,
    input  logic               flag_id,
    input  logic               flag_ep,
    input  logic               flag_np,
    output logic               take,
    output logic [CAUSE_W-1:0] cause
);
    logic [LVL_W-1:0] win_lvl;
    logic             irq_ok;
    logic             exc_hit;

    // Priority encoder: the highest-numbered active line wins.
    always_comb begin
        win_lvl = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_req[i]) win_lvl = LVL_W'(i);
        end
    end

    // Accept logic and cause selection.
    always_comb begin
        exc_hit = (exc_code != '0);
        irq_ok  = (|irq_req) && !flag_id && !flag_ep && !flag_np;
        take    = exc_hit || irq_ok;
        cause   = exc_hit ? exc_code : {IRQ_CLASS, win_lvl, 4'h0};
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Computes the handler address and the updated status word.
// Assumes cause and status word are stable latched values.
module exc_vector_gen
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    psw,
    output logic [XLEN-1:0]    vec_pc,
    output logic [XLEN-1:0]    psw_next
);
    logic [XLEN-1:0] reg_vec;

    // Handler address for the duplexed and regular paths, with the one alias.
    always_comb begin
        reg_vec = {VEC_HI, cause & CAUSE_MASK};
        if (reg_vec == VEC_ALIAS) reg_vec = VEC_ALIASED;
        vec_pc = psw[PSW_EP] ? VEC_DUP : reg_vec;
    end

    // Status word on entry: mask traps, drop the address trap, set level for interrupts.
    always_comb begin
        psw_next         = psw;
        psw_next[PSW_AE] = 1'b0;
        psw_next[PSW_ID] = 1'b1;
        if (cause[CAUSE_W-1 -: 8] == IRQ_CLASS)
            psw_next[PSW_LVL_LSB +: LVL_W] = cause[4 +: LVL_W];
    end
endmodule

// File: rtl/exc_dump_ctrl.sv
// Streams the three-word crash record over a valid/ready write port.
// Assumes the record inputs stay stable from start until done.
module exc_dump_ctrl
    import exc_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    psw,
    input  logic [XLEN-1:0]    pc,
    input  logic               mem_ready,
    output logic               mem_valid,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_data,
    output logic               done
);
    localparam int IDX_W = $clog2(DUMP_WORDS);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             last;
    logic             fire;

    // Handshake decode.
    always_comb begin
        last      = (idx_q == IDX_W'(DUMP_WORDS - 1));
        mem_valid = active_q;
        fire      = active_q && mem_ready;
        done      = fire && last;
        mem_addr  = XLEN'(idx_q) << 2;
    end

    // Word selection by index.
    always_comb begin
        case (idx_q)
            IDX_W'(0): mem_data = {VEC_HI, cause};
            IDX_W'(1): mem_data = psw;
            default:   mem_data = pc;
        endcase
    end

    // Word counter and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (fire) begin
            idx_q    <= last ? '0 : idx_q + 1'b1;
            if (last) active_q <= 1'b0;
        end
    end

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_addr <= XLEN'(8)));
endmodule

// File: rtl/exc_entry_seq.sv
// Top of the trap entry sequencer: takes a trap at a check strobe, optionally
// writes the crash record, then applies one cycle of save/vector updates.
// Assumes the pipeline holds while busy and commits the outputs when refetch is high.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_en,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [CAUSE_W-1:0] exc_code,
    input  logic [XLEN-1:0]    psw_in,
    input  logic [XLEN-1:0]    pc_in,
    input  logic               mem_ready,
    output logic               busy,
    output logic               mem_valid,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_data,
    output logic               refetch,
    output logic [XLEN-1:0]    new_pc,
    output logic [XLEN-1:0]    psw_out,
    output logic [XLEN-1:0]    save_pc,
    output logic [XLEN-1:0]    save_psw,
    output logic [CAUSE_W-1:0] save_cause,
    output logic               save_reg_we,
    output logic               save_dup_we
);
    seq_state_t         state_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [XLEN-1:0]    psw_q;
    logic [XLEN-1:0]    pc_q;
    logic               arb_take;
    logic [CAUSE_W-1:0] arb_cause;
    logic               take_now;
    logic               dump_start;
    logic               dump_done;

    exc_irq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .irq_req  (irq_req),
        .exc_code (exc_code),
        .flag_id  (psw_in[PSW_ID]),
        .flag_ep  (psw_in[PSW_EP]),
        .flag_np  (psw_in[PSW_NP]),
        .take     (arb_take),
        .cause    (arb_cause)
    );

    exc_dump_ctrl u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dump_start),
        .cause     (cause_q),
        .psw       (psw_q),
        .pc        (pc_q),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .done      (dump_done)
    );

    exc_vector_gen u_vec (
        .cause    (cause_q),
        .psw      (psw_q),
        .vec_pc   (new_pc),
        .psw_next (psw_out)
    );

    // Trap is taken only from idle.
    always_comb begin
        take_now   = (state_q == ST_IDLE) && chk_en && arb_take;
        dump_start = take_now && psw_in[PSW_NP];
    end

    // Sequencer state and entry latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
            psw_q   <= '0;
            pc_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (take_now) begin
                    cause_q <= arb_cause;
                    psw_q   <= psw_in;
                    pc_q    <= pc_in;
                    state_q <= psw_in[PSW_NP] ? ST_DUMP : ST_APPLY;
                end
                ST_DUMP:  if (dump_done) state_q <= ST_APPLY;
                ST_APPLY: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Apply-cycle outputs.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        refetch     = (state_q == ST_APPLY);
        save_reg_we = refetch && !psw_q[PSW_EP];
        save_dup_we = refetch &&  psw_q[PSW_EP];
        save_pc     = pc_q;
        save_psw    = psw_q;
        save_cause  = cause_q;
    end

    a_r10_refetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |=> !refetch);

    a_r5_one_save_pair: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> (save_reg_we != save_dup_we));

    a_r7_no_alias_vector: assert property (@(posedge clk) disable iff (!rst_n)
        save_reg_we |-> (new_pc != VEC_ALIAS));

    a_r9_psw_masked: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> (psw_out[PSW_ID] && !psw_out[PSW_AE]));

    a_r8_level_from_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (refetch && save_cause[15:8] == IRQ_CLASS) |-> (psw_out[PSW_LVL_LSB +: LVL_W] == save_cause[7:4]));

    a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);

    a_r10_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> ($stable(save_pc) && $stable(save_cause)));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic [4:0]  irq_req = '0;
    logic [15:0] exc_code = '0;
    logic [31:0] psw_in = '0;
    logic [31:0] pc_in = '0;
    logic        mem_ready = 1'b0;
    logic        busy, mem_valid, refetch, save_reg_we, save_dup_we;
    logic [31:0] mem_addr, mem_data, new_pc, psw_out, save_pc, save_psw;
    logic [15:0] save_cause;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .irq_req(irq_req),
        .exc_code(exc_code), .psw_in(psw_in), .pc_in(pc_in), .mem_ready(mem_ready),
        .busy(busy), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .refetch(refetch), .new_pc(new_pc), .psw_out(psw_out), .save_pc(save_pc),
        .save_psw(save_psw), .save_cause(save_cause), .save_reg_we(save_reg_we),
        .save_dup_we(save_dup_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // flags = {np, ep, id}; stall = ready-low cycles before each write; hold keeps chk_en high.
    task automatic run(input logic [15:0] exc, input logic [4:0] irq, input logic [2:0] flags,
                       input logic [31:0] pc, input int stall, input bit hold);
        logic [31:0] psw, exp_pc, exp_psw;
        logic [15:0] cause;
        bit acc;
        int lvl;
        psw = 32'h0009_02A5 | (32'(flags[2]) << 15) | (32'(flags[1]) << 14)
            | (32'h1 << 13) | (32'(flags[0]) << 12);
        lvl = 0;
        for (int i = 0; i < 5; i++) if (irq[i]) lvl = i;
        acc   = (exc != 0) || (irq != 0 && flags == 3'b000);
        cause = (exc != 0) ? exc : (16'hFE00 | 16'(lvl << 4));
        exp_pc = flags[1] ? 32'hFFFFFFD0 : {16'hFFFF, cause & 16'hFFF0};
        if (!flags[1] && exp_pc == 32'hFFFFFF70) exp_pc = 32'hFFFFFF60;
        exp_psw = psw & ~32'h0000_2000 | 32'h0000_1000;
        if (cause[15:8] == 8'hFE) exp_psw = {exp_psw[31:20], cause[7:4], exp_psw[15:0]};

        @(negedge clk);
        chk_en = 1'b1; irq_req = irq; exc_code = exc; psw_in = psw; pc_in = pc;
        @(posedge clk);
        @(negedge clk);
        if (!hold) chk_en = 1'b0;
        exc_code = 16'h0040; pc_in = ~pc; irq_req = 5'h1F; psw_in = 32'h0;
        if (!acc) begin
            chk("R1 busy when not taken", {31'b0, busy}, 32'd0);
            chk("R1 refetch when not taken", {31'b0, refetch}, 32'd0);
            chk_en = 1'b0;
            return;
        end
        if (flags[2]) begin
            for (int w = 0; w < 3; w++) begin
                for (int s = 0; s < stall; s++) begin
                    chk("R4 valid under stall", {31'b0, mem_valid}, 32'd1);
                    chk("R4 addr under stall", mem_addr, 32'(w * 4));
                    chk("R10 no early refetch", {31'b0, refetch}, 32'd0);
                    @(posedge clk); @(negedge clk);
                end
                mem_ready = 1'b1;
                chk("R4 valid", {31'b0, mem_valid}, 32'd1);
                chk("R4 addr", mem_addr, 32'(w * 4));
                chk("R4 data", mem_data, (w == 0) ? {16'hFFFF, cause} : (w == 1) ? psw : pc);
                @(posedge clk); @(negedge clk);
                mem_ready = 1'b0;
            end
        end else begin
            chk("R4 no write without NP", {31'b0, mem_valid}, 32'd0);
        end
        chk("R10 refetch pulse", {31'b0, refetch}, 32'd1);
        chk("R10 busy in apply", {31'b0, busy}, 32'd1);
        chk("R3 R2 cause", {16'b0, save_cause}, {16'b0, cause});
        chk("R10 latched pc", save_pc, pc);
        chk("R10 latched psw", save_psw, psw);
        chk("R5 dup we", {31'b0, save_dup_we}, {31'b0, flags[1]});
        chk("R6 reg we", {31'b0, save_reg_we}, {31'b0, ~flags[1]});
        chk(flags[1] ? "R5 vector" : "R6 R7 vector", new_pc, exp_pc);
        chk("R8 R9 psw out", psw_out, exp_psw);
        @(negedge clk);
        chk_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 idle after apply", {31'b0, busy}, 32'd0);
        chk("R10 single pulse", {31'b0, refetch}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 refetch", {31'b0, refetch}, 32'd0);
        chk("R11 mem_valid", {31'b0, mem_valid}, 32'd0);
        chk("R11 save we", {30'b0, save_reg_we, save_dup_we}, 32'd0);
        // R1 R2: every request pattern against every flag combination.
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 32; r++)
                run(16'h0, 5'(r), 3'(f), 32'h1000_0000 + 32'(r * 4 + f * 256), r % 3, 1'b0);
        // R3 R6 R7 R8: exception codes with competing requests, all flags.
        for (int f = 0; f < 8; f++) begin
            run(16'hFF90, 5'h15, 3'(f), 32'h0700_0010, 1, 1'b0);
            run(16'hFF70, 5'h00, 3'(f), 32'h0700_0020, 0, 1'b0);
            run(16'hFF60, 5'h1F, 3'(f), 32'h0700_0030, 2, 1'b0);
            run(16'hFE30, 5'h01, 3'(f), 32'h0700_0040, 0, 1'b0);
            run(16'h1234, 5'h08, 3'(f), 32'h0700_0050, 1, 1'b0);
            run(16'hFE70, 5'h00, 3'(f), 32'h0700_0060, 0, 1'b0);
        end
        // R10: strobe held high and inputs changed while busy.
        run(16'hFF90, 5'h00, 3'b100, 32'h0ABC_0000, 1, 1'b1);
        run(16'h0000, 5'h04, 3'b000, 32'h0ABC_0100, 0, 1'b1);
        run(16'h0A00, 5'h00, 3'b010, 32'h0ABC_0200, 0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule